// File: doc/BRIEF.md
# Serial Audio Link Power-Down Controller

This block is the codec-side manager of a frame-based serial audio link. It generates the bit clock from a free-running master clock, tracks the bit position inside each frame and keeps the codec's control register bank. Register writes reach it already decoded from the command slots of the output frame. A write to the power-down register with the link-halt bit set stops the bit clock and holds the serial input data line low. The register contents survive the halt.

The halted link comes back in one of two ways. An asynchronous cold reset restarts the clock and returns every register to its default. A warm reset does the same for the clock but keeps the registers: the controller holds the frame-sync line high long enough and then releases it. A warm reset is accepted only after a guard time of several frame periods has passed since the halt. A write to the reset register returns the registers to their defaults without stopping the link. A ready flag rises a programmable number of frames after the clock starts. It is sent in the first bit of every input frame, which is the most significant bit of the tag slot.

Top module: `codec_link_pm`

## Requirements
- R1: While `rst_ni` is low, asynchronously and without waiting for a clock edge, every stored register reads 0, `bit_clk_o` is low and `codec_ready_o` is low. After release the bit clock toggles.
- R2: In the running state a write to an even address stores the data, and a read of that address returns it. Reads of odd addresses return 0 and writes to odd addresses are dropped. Address 0x00 always reads the constant `CAP_WORD`.
- R3: A write to address 0x26 with data bit 12 set halts the link. From the next sampling point onward `bit_clk_o` and `sdata_o` stay low whatever `sdata_raw_i` does.
- R4: A write to address 0x26 with bit 12 clear is stored like any other register write, and the bit clock keeps running.
- R5: Writes presented while the link is halted change no register.
- R6: After the guard time, holding `sync_i` high for at least `WARM_CYCLES` master clocks and then driving it low restarts the bit clock within a few clocks. All register values are kept.
- R7: A high pulse on `sync_i` shorter than `WARM_CYCLES` clocks does not wake the halted link.
- R8: For `GUARD_FRAMES` frame periods after the halt, `sync_i` activity of any length does not wake the link.
- R9: `codec_ready_o` is low while halted. It is also low until `READY_FRAMES` complete frames have run after any clock start. After that it is high.
- R10: While running, `sdata_o` carries `codec_ready_o` during bit 0 of every frame (the tag slot's MSB) and `sdata_raw_i` during the other bits. With a steady `sdata_raw_i` = 0 and the link ready, any window of one frame period holds exactly one bit period of high output.
- R11: A write to address 0x00 returns all stored registers to 0 while the bit clock keeps running and `codec_ready_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running master clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| sync_i | input | 1 | Frame-sync line from the controller |
| wr_en_i | input | 1 | Decoded register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| sdata_raw_i | input | 1 | Serial input data from the codec's data path |
| bit_clk_o | output | 1 | Bit clock to the link |
| sdata_o | output | 1 | Serial input data to the link, with the ready tag inserted |
| codec_ready_o | output | 1 | Link ready flag |

## Verification
Suppose the power state machine wrongly holds the running state after a halt write. The bit clock then keeps toggling and the raw data keeps passing, and both show at the ports within one master clock. A broken guard or warm-reset counter shows as a bit clock that restarts too early or never restarts. That is visible within a few clocks after `sync_i` falls. A wrong bit or frame counter moves the ready rise by whole frames, and it changes how many high cycles the tag insertion puts in each frame-long window of `sdata_o`. Register retention faults show on the read port right after a wake.

// File: rtl/lk_pm_pkg.sv
package lk_pm_pkg;
   typedef enum logic [1:0] {
      LK_RUN   = 2'd0,
      LK_HALT  = 2'd1,
      LK_ARMED = 2'd2
   } lk_state_e;
endpackage

// File: rtl/lk_regfile.sv
// Control register bank: even addresses hold words, odd ones read as zero,
// word 0 is a read-only capability constant whose write clears the bank.
module lk_regfile #(
   parameter int unsigned            ADDR_W   = 7,
   parameter int unsigned            DATA_W   = 16,
   parameter logic [DATA_W-1:0]      CAP_WORD = 16'h6A90,
   parameter logic [ADDR_W-1:0]      PD_ADDR  = 7'h26
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              clr_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DATA_W-1:0] pd_word_o
);
   localparam int unsigned IDX_W = ADDR_W - 1;
   localparam int unsigned WORDS = 2 ** IDX_W;

   logic [DATA_W-1:0] words [WORDS];
   logic [IDX_W-1:0]  wr_idx;
   logic              wr_even;

   assign wr_idx  = wr_addr_i[ADDR_W-1:1];
   assign wr_even = wr_en_i & ~wr_addr_i[0];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      if (g == 0) begin : g_cap
         assign words[g] = CAP_WORD;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               q <= '0;
            end else if (clr_i) begin
               q <= '0;
            end else if (wr_even && (wr_idx == IDX_W'(g))) begin
               q <= wr_data_i;
            end
         end
         assign words[g] = q;
      end
   end

   assign rd_data_o = rd_addr_i[0] ? '0 : words[rd_addr_i[ADDR_W-1:1]];
   assign pd_word_o = words[PD_ADDR[ADDR_W-1:1]];
endmodule

// File: rtl/lk_pwr_fsm.sv
// Link power state: running, halted (guard then warm-reset detection),
// armed (waiting for sync to fall).
module lk_pwr_fsm
   import lk_pm_pkg::*;
#(
   parameter int unsigned FRAME_BITS   = 256,
   parameter int unsigned HALF_DIV     = 1,
   parameter int unsigned WARM_CYCLES  = 25,
   parameter int unsigned GUARD_FRAMES = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic halt_req_i,
   input  logic sync_i,
   output logic run_o,
   output logic halted_o,
   output logic armed_o,
   output logic guard_busy_o
);
   localparam int unsigned GUARD_CYC = GUARD_FRAMES * FRAME_BITS * 2 * HALF_DIV;
   localparam int unsigned GW        = $clog2(GUARD_CYC + 1);
   localparam int unsigned WW        = $clog2(WARM_CYCLES + 1);

   lk_state_e       state_q;
   logic [GW-1:0]   guard_q;
   logic [WW-1:0]   warm_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LK_RUN;
         guard_q <= '0;
         warm_q  <= '0;
      end else begin
         case (state_q)
            LK_RUN: begin
               warm_q <= '0;
               if (halt_req_i) begin
                  state_q <= LK_HALT;
                  guard_q <= GW'(GUARD_CYC);
               end
            end
            LK_HALT: begin
               if (guard_q != '0) begin
                  guard_q <= guard_q - GW'(1);
                  warm_q  <= '0;
               end else if (sync_i) begin
                  if (warm_q == WW'(WARM_CYCLES - 1)) begin
                     state_q <= LK_ARMED;
                     warm_q  <= '0;
                  end else begin
                     warm_q <= warm_q + WW'(1);
                  end
               end else begin
                  warm_q <= '0;
               end
            end
            LK_ARMED: begin
               if (!sync_i) begin
                  state_q <= LK_RUN;
               end
            end
            default: state_q <= LK_RUN;
         endcase
      end
   end

   assign run_o        = (state_q == LK_RUN);
   assign halted_o     = (state_q == LK_HALT);
   assign armed_o      = (state_q == LK_ARMED);
   assign guard_busy_o = (guard_q != '0);
endmodule

// File: rtl/lk_bitclk.sv
// Bit clock generator with bit-in-frame position and ready frame counting.
module lk_bitclk #(
   parameter int unsigned FRAME_BITS   = 256,
   parameter int unsigned HALF_DIV     = 1,
   parameter int unsigned READY_FRAMES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic sync_rise_i,
   output logic bclk_o,
   output logic tag_bit_o,
   output logic ready_o
);
   localparam int unsigned DW = $clog2(HALF_DIV + 1);
   localparam int unsigned BW = $clog2(FRAME_BITS);
   localparam int unsigned RW = $clog2(READY_FRAMES + 1);

   logic [DW-1:0] div_q;
   logic          bclk_q;
   logic [BW-1:0] bit_q;
   logic [RW-1:0] frm_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q  <= '0;
         bclk_q <= 1'b0;
         bit_q  <= '0;
         frm_q  <= '0;
      end else if (!run_i) begin
         div_q  <= '0;
         bclk_q <= 1'b0;
         bit_q  <= '0;
         frm_q  <= '0;
      end else begin
         if (div_q == DW'(HALF_DIV - 1)) begin
            div_q  <= '0;
            bclk_q <= ~bclk_q;
            if (bclk_q) begin
               if (bit_q == BW'(FRAME_BITS - 1)) begin
                  bit_q <= '0;
                  if (frm_q != RW'(READY_FRAMES)) begin
                     frm_q <= frm_q + RW'(1);
                  end
               end else begin
                  bit_q <= bit_q + BW'(1);
               end
            end
         end else begin
            div_q <= div_q + DW'(1);
         end
         if (sync_rise_i) begin
            bit_q <= '0;
         end
      end
   end

   assign bclk_o    = bclk_q & run_i;
   assign tag_bit_o = run_i & (bit_q == '0);
   assign ready_o   = run_i & (frm_q == RW'(READY_FRAMES));
endmodule

// File: rtl/codec_link_pm.sv
module codec_link_pm #(
   parameter int unsigned       ADDR_W       = 7,
   parameter int unsigned       DATA_W       = 16,
   parameter logic [ADDR_W-1:0] PD_ADDR      = 7'h26,
   parameter logic [ADDR_W-1:0] RST_ADDR     = 7'h00,
   parameter int unsigned       PD_BIT       = 12,
   parameter logic [DATA_W-1:0] CAP_WORD     = 16'h6A90,
   parameter int unsigned       FRAME_BITS   = 256,
   parameter int unsigned       HALF_DIV     = 1,
   parameter int unsigned       READY_FRAMES = 2,
   parameter int unsigned       WARM_CYCLES  = 25,
   parameter int unsigned       GUARD_FRAMES = 4,
   parameter bit                TAG_READY    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sync_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              sdata_raw_i,
   output logic              bit_clk_o,
   output logic              sdata_o,
   output logic              codec_ready_o
);
   if (PD_BIT >= DATA_W) begin : g_bad_pd_bit
      $error("PD_BIT must lie inside the data word");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (HALF_DIV < 1 || READY_FRAMES < 1 || WARM_CYCLES < 1) begin : g_bad_cnt
      $error("HALF_DIV, READY_FRAMES and WARM_CYCLES must be non-zero");
   end
   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("FRAME_BITS must be at least 2");
   end

   logic [2:0]        sync_q;
   logic              sync_lvl;
   logic              sync_rise;
   logic              run;
   logic              halted;
   logic              armed;
   logic              guard_busy;
   logic              wr_ok;
   logic              halt_req;
   logic              soft_clr;
   logic              tag_bit;
   logic [DATA_W-1:0] pd_word;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[1:0], sync_i};
      end
   end

   assign sync_lvl  = sync_q[1];
   assign sync_rise = sync_q[1] & ~sync_q[2];

   assign wr_ok    = wr_en_i & run;
   assign halt_req = wr_ok & (wr_addr_i == PD_ADDR) & wr_data_i[PD_BIT];
   assign soft_clr = wr_ok & (wr_addr_i == RST_ADDR);

   lk_regfile #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CAP_WORD(CAP_WORD),
      .PD_ADDR (PD_ADDR)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_ok),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .clr_i    (soft_clr),
      .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o),
      .pd_word_o(pd_word)
   );

   lk_pwr_fsm #(
      .FRAME_BITS  (FRAME_BITS),
      .HALF_DIV    (HALF_DIV),
      .WARM_CYCLES (WARM_CYCLES),
      .GUARD_FRAMES(GUARD_FRAMES)
   ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .halt_req_i  (halt_req),
      .sync_i      (sync_lvl),
      .run_o       (run),
      .halted_o    (halted),
      .armed_o     (armed),
      .guard_busy_o(guard_busy)
   );

   lk_bitclk #(
      .FRAME_BITS  (FRAME_BITS),
      .HALF_DIV    (HALF_DIV),
      .READY_FRAMES(READY_FRAMES)
   ) u_clk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run),
      .sync_rise_i(sync_rise),
      .bclk_o     (bit_clk_o),
      .tag_bit_o  (tag_bit),
      .ready_o    (codec_ready_o)
   );

   if (TAG_READY) begin : g_tag_ins
      assign sdata_o = run & (tag_bit ? codec_ready_o : sdata_raw_i);
   end else begin : g_tag_off
      logic unused_tag;
      assign unused_tag = tag_bit;
      assign sdata_o    = run & sdata_raw_i;
   end
endmodule

// File: rtl/lk_pm_checker.sv
module lk_pm_checker #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              run,
   input logic              halted,
   input logic              armed,
   input logic              guard_busy,
   input logic              bit_clk_o,
   input logic              sdata_o,
   input logic              codec_ready_o,
   input logic [DATA_W-1:0] pd_word
);
   // R3: a stopped link drives both link outputs low
   a_r3_link_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |-> (!bit_clk_o && !sdata_o));

   // R9: no ready flag without a running clock
   a_r9_no_ready_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |-> !codec_ready_o);

   // R5: the power-down word cannot change while stopped
   a_r5_pd_word_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && $past(!run)) |-> $stable(pd_word));

   // R8: within the guard time the link stays halted
   a_r8_guard_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halted && guard_busy) |=> halted);

   // R6: arming only follows the halted state
   a_r6_arm_after_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(armed) |-> $past(halted));
endmodule

bind codec_link_pm lk_pm_checker #(.DATA_W(DATA_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .run          (run),
   .halted       (halted),
   .armed        (armed),
   .guard_busy   (guard_busy),
   .bit_clk_o    (bit_clk_o),
   .sdata_o      (sdata_o),
   .codec_ready_o(codec_ready_o),
   .pd_word      (pd_word)
);

// File: tb/tb_codec_link_pm.sv
module tb_codec_link_pm;
   localparam int unsigned AW  = 7;
   localparam int unsigned DW  = 16;
   localparam logic [15:0] CAP = 16'h6A90;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          raw = 1'b0;
   logic          bclk;
   logic          sdo;
   logic          ready;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   codec_link_pm #(
      .CAP_WORD    (CAP),
      .FRAME_BITS  (32),
      .HALF_DIV    (1),
      .READY_FRAMES(2),
      .WARM_CYCLES (8),
      .GUARD_FRAMES(4)
   ) dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .sync_i       (sync),
      .wr_en_i      (wr_en),
      .wr_addr_i    (wr_addr),
      .wr_data_i    (wr_data),
      .rd_addr_i    (rd_addr),
      .rd_data_o    (rd_data),
      .sdata_raw_i  (raw),
      .bit_clk_o    (bclk),
      .sdata_o      (sdo),
      .codec_ready_o(ready)
   );

   // {address, write data, expected read}
   localparam logic [38:0] VEC [6] = '{
      {7'h02, 16'h1234, 16'h1234},
      {7'h04, 16'hABCD, 16'hABCD},
      {7'h26, 16'h0F00, 16'h0F00},
      {7'h03, 16'hFFFF, 16'h0000},
      {7'h7E, 16'hBEEF, 16'hBEEF},
      {7'h18, 16'h0001, 16'h0001}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic cnt_bclk(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (bclk) hi++;
      end
   endtask

   task automatic cnt_sdo(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sdo) hi++;
      end
   endtask

   task automatic pulse_sync(input int n);
      @(negedge clk);
      sync = 1'b1;
      tick(n);
      sync = 1'b0;
   endtask

   initial begin
      logic [DW-1:0] d;
      int hi;
      // R1 reset state
      tick(3);
      rd(7'h02, d);
      chk(d == 16'h0, "R1 reg reset", d, 0);
      chk(!ready, "R1 ready low in reset", ready, 0);
      chk(!bclk, "R1 bclk low in reset", bclk, 0);
      rd(7'h00, d);
      chk(d == CAP, "R2 capability word", d, CAP);
      @(negedge clk);
      rst_n = 1'b1;
      cnt_bclk(40, hi);
      chk(hi == 20, "R1 bclk runs after reset", hi, 20);
      chk(!ready, "R9 not ready before two frames", ready, 0);
      tick(110);
      chk(ready, "R9 ready after two frames", ready, 1);

      // R2 / R4 vector table
      for (int i = 0; i < 6; i++) begin
         wr(VEC[i][38:32], VEC[i][31:16]);
         rd(VEC[i][38:32], d);
         chk(d == VEC[i][15:0], "R2 write/read vector", d, VEC[i][15:0]);
      end
      cnt_bclk(20, hi);
      chk(hi == 10, "R4 clock runs after pd write without bit 12", hi, 10);

      // R10 tag insertion
      raw = 1'b0;
      cnt_sdo(64, hi);
      chk(hi == 2, "R10 one tag bit per frame", hi, 2);
      raw = 1'b1;
      cnt_sdo(64, hi);
      chk(hi == 64, "R10 raw data passes", hi, 64);

      // R11 register reset write
      wr(7'h00, 16'h0000);
      rd(7'h02, d);
      chk(d == 16'h0, "R11 reg cleared", d, 0);
      rd(7'h26, d);
      chk(d == 16'h0, "R11 pd reg cleared", d, 0);
      chk(ready, "R11 ready kept", ready, 1);
      cnt_bclk(20, hi);
      chk(hi == 10, "R11 clock kept", hi, 10);
      wr(7'h02, 16'h5A5A);

      // R3 halt
      wr(7'h26, 16'h1000);
      cnt_bclk(50, hi);
      chk(hi == 0, "R3 bclk held low", hi, 0);
      cnt_sdo(20, hi);
      chk(hi == 0, "R3 sdata held low with raw high", hi, 0);
      chk(!ready, "R9 ready low while halted", ready, 0);

      // R5 writes ignored while halted
      wr(7'h02, 16'hFFFF);
      rd(7'h02, d);
      chk(d == 16'h5A5A, "R5 halted write ignored", d, 16'h5A5A);

      // R8 sync inside guard time
      pulse_sync(100);
      cnt_bclk(20, hi);
      chk(hi == 0, "R8 no wake in guard", hi, 0);
      tick(150);

      // R7 short sync pulse
      pulse_sync(4);
      cnt_bclk(40, hi);
      chk(hi == 0, "R7 short pulse no wake", hi, 0);

      // R6 warm reset
      raw = 1'b0;
      pulse_sync(20);
      cnt_bclk(20, hi);
      chk(hi > 0, "R6 clock restarts after warm reset", hi, 1);
      rd(7'h02, d);
      chk(d == 16'h5A5A, "R6 register kept", d, 16'h5A5A);
      rd(7'h26, d);
      chk(d == 16'h1000, "R6 pd register kept", d, 16'h1000);
      cnt_sdo(64, hi);
      chk(hi == 0, "R10 tag low before ready", hi, 0);
      chk(!ready, "R9 not ready soon after wake", ready, 0);
      tick(100);
      chk(ready, "R9 ready after wake frames", ready, 1);

      // R1 asynchronous cold reset
      rd_addr = 7'h02;
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      chk(rd_data == 16'h0, "R1 async reg clear", rd_data, 0);
      chk(!ready && !bclk, "R1 async outputs low", {ready, bclk}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cnt_bclk(20, hi);
      chk(hi == 10, "R1 clock after cold reset", hi, 10);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule